// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block generates a repeated start condition for an I2C master. A one-cycle request, taken only while the sequencer is idle and no other bus event is in progress, runs a fixed series of bus phases. The block drives open-drain drive-low enables for SCL and SDA. It samples the real bus levels, so a phase moves on only after the bus has reached the level the block expects. A slave that holds SCL low therefore stretches the sequence without breaking it.

A baud-rate down-counter sets the length of each phase. The counter is loaded from a programmable reload value. The first phase, with SCL low and SDA released, uses only the low six bits of that value. The later phases use all seven bits. A phase loaded with value N lasts N+1 clock cycles.

When the final phase ends, SDA is left driven low, ready for the address byte that the surrounding master logic will send. The block also raises a completion flag. A start-detect flag watches the bus pins for a start condition. A collision flag reports two cases in which another master disturbs the sequence.

Top module: `i2c_rstart_seq`

## Requirements
- R1: A request strobe takes effect only when `rs_pending` is 0 and `busy` is 0. A strobe with `busy` high, or one arriving while a sequence runs, changes neither the outputs nor the sequence timing.
- R2: On an accepted request, `scl_drive_low` goes to 1. Once SCL is sampled low, SDA is released and SCL is held low for `reload[5:0]`+1 further cycles; bit 6 of `reload` has no effect on this phase. On an idle bus, `scl_drive_low` is 1 for exactly `reload[5:0]`+2 cycles.
- R3: When the SCL-low phase has expired and SDA is sampled high, SCL is released. The counter is loaded with `reload[6:0]` only once SCL is sampled high. A slave holding SCL low for K cycles delays completion by exactly K cycles.
- R4: After SCL and SDA have both been high for `reload`+1 cycles, `sda_drive_low` goes to 1 with SCL still released, for `reload`+1 cycles. On an unstretched bus, `done_irq` is first seen `reload[5:0]`+2·`reload`+6 cycles after the request is driven.
- R5: At completion, `rs_pending` falls in the same cycle that `done_irq` rises. `sda_drive_low` then stays 1, and `scl_drive_low` stays 0, until the next accepted request.
- R6: `start_seen` goes to 1 on the clock after the bus shows SDA falling while SCL is high. During a sequence with `reload` ≥ 1, it is already 1 before `done_irq` rises.
- R7: `collision` is set if SDA is sampled low when SCL is first sampled high after the block releases it.
- R8: `collision` is set if SCL is sampled low during the both-high setup phase, before the block drives SDA low.
- R9: On a collision, both drive enables go to 0, `rs_pending` clears and `done_irq` stays 0.
- R10: Synchronous active-high `rst` sets all outputs to 0. `done_irq`, `start_seen` and `collision` stay set until the next accepted request clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rs_req | input | 1 | Single-cycle repeated-start request |
| reload | input | 7 | Baud-rate reload value |
| busy | input | 1 | Another bus event is in progress |
| scl_in | input | 1 | Sampled SCL bus level |
| sda_in | input | 1 | Sampled SDA bus level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| rs_pending | output | 1 | Sequence in progress |
| start_seen | output | 1 | Start condition observed on the bus |
| done_irq | output | 1 | Sequence completed |
| collision | output | 1 | Bus collision detected |

## Verification
The assertions check these properties on every cycle:
- A busy-time strobe is refused.
- Completion and collision exclude each other whenever pending falls.
- SDA stays held while the completion flag is up.
- Both lines are released whenever a collision is flagged.
- A start on the pins always sets the start flag.

Phase lengths cannot be checked cycle by cycle by a property. The bench's scenarios show them instead: the split of the reload value between the first phase and the later phases, the exact delay added by clock stretching, and the two collision cases. The bench produces each collision case with a modelled slave on the open-drain lines.

// File: rtl/i2c_rstart_seq.sv
module i2c_rstart_seq #(
  parameter int RELOAD_W = 7,
  parameter int FIRST_W  = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rs_req,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                busy,
  input  logic                scl_in,
  input  logic                sda_in,
  output logic                scl_drive_low,
  output logic                sda_drive_low,
  output logic                rs_pending,
  output logic                start_seen,
  output logic                done_irq,
  output logic                collision
);

  typedef enum logic [2:0] {
    S_IDLE, S_PULL, S_SDAREL, S_SCLREL, S_SETUP, S_HOLD
  } st_t;

  st_t                 st;
  logic [RELOAD_W-1:0] cnt;
  logic                sda_hold;
  logic                scl_q, sda_q;

  logic                accept, expired, bus_start, coll_edge, coll_low;
  logic [RELOAD_W-1:0] first_load;

  assign accept     = rs_req && !busy && (st == S_IDLE);
  assign expired    = (cnt == '0);
  assign first_load = RELOAD_W'(reload[FIRST_W-1:0]);
  assign bus_start  = scl_in && scl_q && sda_q && !sda_in;
  assign coll_edge  = (st == S_SCLREL) && scl_in && !sda_in;
  assign coll_low   = (st == S_SETUP) && !scl_in;

  assign scl_drive_low = (st == S_PULL) || (st == S_SDAREL);
  assign sda_drive_low = (st == S_HOLD) || sda_hold;
  assign rs_pending    = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cnt        <= '0;
      sda_hold   <= 1'b0;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      start_seen <= 1'b0;
      done_irq   <= 1'b0;
      collision  <= 1'b0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (accept) begin
        done_irq   <= 1'b0;
        collision  <= 1'b0;
        start_seen <= 1'b0;
      end
      if (bus_start) start_seen <= 1'b1;

      case (st)
        S_IDLE: if (accept) st <= S_PULL;
        S_PULL: if (!scl_in) begin
          cnt      <= first_load;
          sda_hold <= 1'b0;
          st       <= S_SDAREL;
        end
        S_SDAREL: begin
          if (!expired) cnt <= cnt - 1'b1;
          else if (sda_in) st <= S_SCLREL;
        end
        S_SCLREL: begin
          if (coll_edge) begin
            collision <= 1'b1;
            st        <= S_IDLE;
          end else if (scl_in) begin
            cnt <= reload;
            st  <= S_SETUP;
          end
        end
        S_SETUP: begin
          if (coll_low) begin
            collision <= 1'b1;
            st        <= S_IDLE;
          end else if (sda_in) begin
            if (!expired) cnt <= cnt - 1'b1;
            else begin
              cnt <= reload;
              st  <= S_HOLD;
            end
          end
        end
        S_HOLD: begin
          if (!expired) cnt <= cnt - 1'b1;
          else begin
            done_irq <= 1'b1;
            sda_hold <= 1'b1;
            st       <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_rstart_seq_chk.sv
module i2c_rstart_seq_chk (
  input logic clk,
  input logic rst,
  input logic rs_req,
  input logic busy,
  input logic scl_in,
  input logic sda_in,
  input logic scl_drive_low,
  input logic sda_drive_low,
  input logic rs_pending,
  input logic start_seen,
  input logic done_irq,
  input logic collision
);

  assert_busy_refused_R1: assert property (@(posedge clk) disable iff (rst)
    (rs_req && busy && !rs_pending) |=> !rs_pending);

  assert_end_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(rs_pending) |-> (done_irq ^ collision));

  assert_sda_held_after_done_R5: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> (sda_drive_low && !scl_drive_low && !rs_pending));

  assert_start_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (scl_in && $past(scl_in) && $past(sda_in) && !sda_in) |=> start_seen);

  assert_collision_release_R9: assert property (@(posedge clk) disable iff (rst)
    collision |-> (!scl_drive_low && !sda_drive_low && !done_irq && !rs_pending));

endmodule

bind i2c_rstart_seq i2c_rstart_seq_chk u_chk (
  .clk(clk), .rst(rst), .rs_req(rs_req), .busy(busy),
  .scl_in(scl_in), .sda_in(sda_in),
  .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
  .rs_pending(rs_pending), .start_seen(start_seen),
  .done_irq(done_irq), .collision(collision)
);

// File: tb/tb_i2c_rstart_seq.sv
module tb_i2c_rstart_seq;
  logic clk = 0, rst = 1, rs_req = 0, busy = 0;
  logic [6:0] reload = '0;
  logic slv_scl = 0, slv_sda = 0;
  logic scl_bus, sda_bus;
  logic scl_dl, sda_dl, pend, st_seen, done, coll;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign scl_bus = !(scl_dl || slv_scl);
  assign sda_bus = !(sda_dl || slv_sda);

  i2c_rstart_seq dut (
    .clk(clk), .rst(rst), .rs_req(rs_req), .reload(reload), .busy(busy),
    .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_drive_low(scl_dl), .sda_drive_low(sda_dl), .rs_pending(pend),
    .start_seen(st_seen), .done_irq(done), .collision(coll)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input int r, input int k, input bit midreq,
                         output int cyc, output int sclc, output int sdac, output bit early);
    int left = 0;
    bit prev = 0;
    cyc = 0; sclc = 0; sdac = 0; early = 0;
    reload = 7'(r);
    rs_req = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      rs_req = 0;
      cyc++;
      if (done) break;
      if (scl_dl) sclc++;
      else if (sda_dl) sdac++;
      if (st_seen) early = 1;
      if (midreq && cyc == 3) rs_req = 1;
      if (k > 0 && prev && !scl_dl) begin
        slv_scl = 1; left = k;
      end else if (left > 0) begin
        left--;
        if (left == 0) slv_scl = 0;
      end
      prev = scl_dl;
    end
    slv_scl = 0;
  endtask

  task automatic t_reset;
    check(!scl_dl && !sda_dl, "R10 drives after reset", {scl_dl, sda_dl}, 0);
    check(!pend && !st_seen && !done && !coll, "R10 flags after reset",
          {pend, st_seen, done, coll}, 0);
  endtask

  task automatic t_normal(input int r);
    int cyc, sclc, sdac, l;
    bit early;
    l = r % 64;
    run_seq(r, 0, 0, cyc, sclc, sdac, early);
    check(sclc == l + 2, "R2 scl low cycles", sclc, l + 2);
    check(sdac == r + 1, "R4 sda low cycles", sdac, r + 1);
    check(cyc == l + 2*r + 6, "R4 request to done", cyc, l + 2*r + 6);
    check(!pend && !coll, "R5 pending cleared at done", {pend, coll}, 0);
    check(st_seen, "R6 start seen at done", st_seen, 1);
    if (r >= 1) check(early, "R6 start seen before done", early, 1);
    repeat (3) @(negedge clk);
    check(sda_dl && !scl_dl && done, "R5 sda held after done", {sda_dl, scl_dl, done}, 5);
  endtask

  task automatic t_busy;
    busy = 1; rs_req = 1;
    @(negedge clk);
    rs_req = 0; busy = 0;
    check(!pend && !scl_dl, "R1 busy request refused", {pend, scl_dl}, 0);
    repeat (2) @(negedge clk);
    check(!pend && !scl_dl && done, "R1 busy request no effect", {pend, scl_dl, done}, 1);
  endtask

  task automatic t_midreq;
    int cyc, sclc, sdac;
    bit early;
    run_seq(10, 0, 1, cyc, sclc, sdac, early);
    check(cyc == 10 + 20 + 6, "R1 request during sequence ignored", cyc, 36);
  endtask

  task automatic t_stretch;
    int cyc, sclc, sdac;
    bit early;
    run_seq(70, 5, 0, cyc, sclc, sdac, early);
    check(cyc == 6 + 140 + 6 + 5, "R3 stretch adds delay", cyc, 157);
    check(sclc == 8, "R3 stretch scl drive", sclc, 8);
  endtask

  task automatic t_coll_rise;
    bit prev = 0;
    reload = 7'd20; rs_req = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      rs_req = 0;
      if (prev && !scl_dl) break;
      prev = scl_dl;
    end
    slv_scl = 1; slv_sda = 1;
    repeat (2) @(negedge clk);
    slv_scl = 0;
    @(negedge clk);
    check(coll, "R7 sda low at scl rise", coll, 1);
    check(!scl_dl && !sda_dl && !pend, "R9 release on collision", {scl_dl, sda_dl, pend}, 0);
    slv_sda = 0;
    repeat (30) @(negedge clk);
    check(!done && coll, "R9 no done after collision", {done, coll}, 1);
  endtask

  task automatic t_coll_setup;
    bit prev = 0;
    reload = 7'd30; rs_req = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      rs_req = 0;
      if (prev && !scl_dl) break;
      prev = scl_dl;
    end
    check(!coll, "R10 collision cleared by request", coll, 0);
    repeat (4) @(negedge clk);
    slv_scl = 1;
    @(negedge clk);
    slv_scl = 0;
    check(coll, "R8 scl low during setup", coll, 1);
    check(!scl_dl && !sda_dl && !pend, "R9 release on setup collision", {scl_dl, sda_dl, pend}, 0);
    repeat (80) @(negedge clk);
    check(!done, "R9 no done after setup collision", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_normal(67);
    t_busy();
    t_normal(0);
    t_midreq();
    t_stretch();
    t_coll_rise();
    t_coll_setup();
    t_normal(5);
    check(!coll, "R10 collision cleared after new sequence", coll, 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule